// File: doc/BRIEF.md
# Host-Stepped Two-Wire Bus Master

This block is a two-wire (I2C) bus master that a host drives one bus phase at a time through a small register window. The host asks for a START, then loads a byte and acknowledges the step. Each time a phase ends, the block sets a step flag, holds SCL low, and publishes an 8-bit status code that names the phase and how it went. The host reads that code and then chooses the next step: another byte, a repeated START, or a STOP.

Both bus lines are open-drain. The block pulls a line low by asserting its `*_oe` output, and it reads the actual line levels back on `scl_in` and `sda_in`. One register location serves two purposes: a read returns the status code and a write sets the bit-rate divider. A write of any value to the soft-reset location puts the whole controller back into its reset state. Slave mode, 10-bit addressing, arbitration and clock stretching are not part of this block.

Register window (`reg_addr`): 0 control, 1 data, 2 status (read) / divider (write), 3 own address, 4 extended own address, 5 soft reset. Control bits: 7 interrupt enable, 6 enable, 5 START, 4 STOP, 3 step flag, 2 ACK.

Top module: `twi_step_master`

## Requirements
- R1: After reset the status reads 0xF8, the control register reads 0x00, `irq` is low, and both `scl_oe` and `sda_oe` are low.
- R2: A control write with bit 6 and bit 5 set while the bus is free sends a START and ends with status 0x08. The same write while the master holds the bus sends a repeated START and ends with status 0x10. Either way the step flag (control bit 3) is set.
- R3: The first byte after a START or repeated START is an address, and its bit 0 gives the direction (1 = read). The step ends with 0x18 for write+ACK, 0x20 for write+NAK, 0x40 for read+ACK and 0x48 for read+NAK.
- R4: A data byte is sent MSB first. The step ends with 0x28 if the slave ACKs it and 0x30 if the slave NAKs it.
- R5: For a received byte, the master returns ACK when control bit 2 is 1 (status 0x50) and NAK when it is 0 (status 0x58). The byte can then be read at the data register.
- R6: A control write with bit 6 set and bit 3 clear, made while the flag is set, clears the flag and launches the next byte. The byte is transmitted if the data register was written since the last launch, and received otherwise. A write with bit 3 set launches nothing.
- R7: A control write with bit 6 and bit 4 set, made while the bus is held, sends a STOP. The flag does not rise. Once both lines read high, the status returns to 0xF8 and both lines are released.
- R8: While control bit 6 is written as 0, a START request is ignored: the status stays 0xF8, the flag stays clear and both lines stay released.
- R9: `irq` is high exactly when the step flag and control bit 7 are both set.
- R10: A write to location 2 sets the divider D, with reset value 0x44. Each quarter of a bit time lasts D+1 clocks, so SCL stays high for 2*(D+1) clocks per bit.
- R11: A write of any value to location 5 returns the controller to idle and restores the reset values of the divider, own address, extended own address and control register.
- R12: While the flag is set, SCL is held low. During a byte, SDA does not change while SCL is high.
- R13: In a single control write, STOP takes priority over START, and START takes priority over a byte launch. A data byte still waiting to be sent stays queued behind a repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Step interrupt |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
One control write can ask for several actions at once. A START request and the byte-launch rule can both apply to the same write, and a STOP can be requested together with a START. The bench provokes the first case by loading the data register and then writing START with the flag bit clear while the bus is held. It expects status 0x10, followed by that queued byte going out as a read address with status 0x40. It provokes the second case by writing STOP and START together after an address NAK, and expects the bus to come back to 0xF8 with no flag raised.

// File: rtl/twi_step_master.sv
module twi_step_master #(
  parameter logic [7:0] BAUD_RST = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [2:0] A_CTRL = 3'd0, A_DATA = 3'd1, A_STAT = 3'd2,
                         A_OWN = 3'd3, A_OWNX = 3'd4, A_SRST = 3'd5;

  typedef enum logic [2:0] {OP_START, OP_RSTART, OP_STOP, OP_TX, OP_RX} op_t;

  logic [7:0] baud, own_a, own_x, data_r, stat, sh, cnt;
  logic       ie, en, ackb, iflg, pend, busy, held, rw, is_addr, got;
  logic       last, scl_lo, sda_lo, bit_op;
  op_t        op;
  logic [1:0] ph;
  logic [3:0] bitn;

  assign bit_op = (op == OP_TX) || (op == OP_RX);
  assign irq    = iflg & ie;
  assign scl_oe = en & scl_lo;
  assign sda_oe = en & sda_lo;

  always_comb
    case (op)
      OP_START:  last = ph == 2'd2;
      OP_RSTART: last = ph == 2'd3;
      OP_STOP:   last = (ph == 2'd2) && scl_in && sda_in;
      default:   last = (ph == 2'd3) && (bitn == 4'd8);
    endcase

  always_comb begin
    scl_lo = held;
    sda_lo = 1'b0;
    if (busy)
      case (op)
        OP_START:  begin scl_lo = ph == 2'd2;                  sda_lo = ph != 2'd0; end
        OP_RSTART: begin scl_lo = ph == 2'd0 || ph == 2'd3;    sda_lo = ph[1];      end
        OP_STOP:   begin scl_lo = ph == 2'd0;                  sda_lo = ph != 2'd2; end
        default: begin
          scl_lo = !ph[1];
          sda_lo = (bitn == 4'd8) ? (op == OP_RX && ackb) : (op == OP_TX && !sh[7]);
        end
      endcase
  end

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {ie, en, 2'b00, iflg, ackb, 2'b00};
      A_DATA:  reg_rdata = data_r;
      A_STAT:  reg_rdata = stat;
      A_OWN:   reg_rdata = own_a;
      A_OWNX:  reg_rdata = own_x;
      default: reg_rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud <= BAUD_RST; own_a <= '0; own_x <= '0; data_r <= '0; stat <= 8'hF8;
      sh <= '0; cnt <= '0; ie <= 1'b0; en <= 1'b0; ackb <= 1'b0; iflg <= 1'b0;
      pend <= 1'b0; busy <= 1'b0; held <= 1'b0; rw <= 1'b0; is_addr <= 1'b0;
      got <= 1'b0; op <= OP_START; ph <= '0; bitn <= '0;
    end else if (reg_wr && reg_addr == A_SRST) begin
      baud <= BAUD_RST; own_a <= '0; own_x <= '0; data_r <= '0; stat <= 8'hF8;
      sh <= '0; cnt <= '0; ie <= 1'b0; en <= 1'b0; ackb <= 1'b0; iflg <= 1'b0;
      pend <= 1'b0; busy <= 1'b0; held <= 1'b0; rw <= 1'b0; is_addr <= 1'b0;
      got <= 1'b0; op <= OP_START; ph <= '0; bitn <= '0;
    end else begin
      if (reg_wr)
        case (reg_addr)
          A_CTRL: begin ie <= reg_wdata[7]; en <= reg_wdata[6]; ackb <= reg_wdata[2]; end
          A_DATA: begin data_r <= reg_wdata; pend <= 1'b1; end
          A_STAT: baud <= reg_wdata;
          A_OWN:  own_a <= reg_wdata;
          A_OWNX: own_x <= reg_wdata;
          default: ;
        endcase

      if (busy) begin
        if (cnt != 8'd0) cnt <= cnt - 8'd1;
        else begin
          cnt <= baud;
          if (bit_op && ph == 2'd2) got <= sda_in;
          if (last) begin
            busy <= 1'b0;
            case (op)
              OP_START:  begin held <= 1'b1; stat <= 8'h08; iflg <= 1'b1; end
              OP_RSTART: begin stat <= 8'h10; iflg <= 1'b1; end
              OP_STOP:   begin held <= 1'b0; stat <= 8'hF8; end
              OP_TX: begin
                iflg <= 1'b1;
                if (is_addr) stat <= rw ? (got ? 8'h48 : 8'h40) : (got ? 8'h20 : 8'h18);
                else         stat <= got ? 8'h30 : 8'h28;
              end
              default: begin data_r <= sh; stat <= ackb ? 8'h50 : 8'h58; iflg <= 1'b1; end
            endcase
          end else if (!(op == OP_STOP && ph == 2'd2)) begin
            ph <= ph + 2'd1;
            if (bit_op && ph == 2'd3) begin
              bitn <= bitn + 4'd1;
              sh   <= {sh[6:0], got};
            end
          end
        end
      end else if (reg_wr && reg_addr == A_CTRL && reg_wdata[6]) begin
        if (reg_wdata[4] && held) begin
          op <= OP_STOP; busy <= 1'b1; ph <= '0; cnt <= baud; iflg <= 1'b0;
        end else if (reg_wdata[5]) begin
          op <= held ? OP_RSTART : OP_START;
          busy <= 1'b1; ph <= '0; cnt <= baud; iflg <= 1'b0;
        end else if (iflg && !reg_wdata[3] && held) begin
          busy <= 1'b1; ph <= '0; cnt <= baud; iflg <= 1'b0; bitn <= '0;
          if (pend) begin
            op <= OP_TX; sh <= data_r; pend <= 1'b0; rw <= data_r[0];
            is_addr <= (stat == 8'h08) || (stat == 8'h10);
          end else op <= OP_RX;
        end
      end
    end
  end
endmodule

// File: rtl/twi_step_master_chk.sv
module twi_step_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       wr_en_bit,
  input logic       scl_in,
  input logic       sda_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] stat,
  input logic       iflg,
  input logic       busy,
  input logic [2:0] op,
  input logic [1:0] ph,
  input logic [7:0] cnt
);
  p_flag_holds_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    iflg |-> scl_oe);

  p_sda_steady_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op >= 3'd3 && !scl_oe && $past(!scl_oe) && $past(busy)) |-> $stable(sda_oe));

  p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == 3'd0 && ph == 2'd2 && cnt == 8'd0) |=> (iflg && stat == 8'h08));

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == 3'd2 && ph == 2'd2 && cnt == 8'd0 && scl_in && sda_in && !reg_wr)
      |=> (!iflg && stat == 8'hF8 && !scl_oe && !sda_oe));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5) |=> (stat == 8'hF8 && !iflg && !busy));

  p_disabled_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !wr_en_bit && !busy) |=> !busy);
endmodule

bind twi_step_master twi_step_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wr_en_bit(reg_wdata[6]), .scl_in(scl_in), .sda_in(sda_in),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .stat(stat), .iflg(iflg), .busy(busy),
  .op(op), .ph(ph), .cnt(cnt)
);

// File: tb/tb_twi_step_master.sv
`timescale 1ns/1ps
module tb_twi_step_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, scl_oe, sda_oe, s_drive = 1'b0;
  logic scl, sda;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | s_drive);

  twi_step_master dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_in(scl), .sda_in(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  localparam logic [7:0] C_IE = 8'h80, C_EN = 8'h40, C_STA = 8'h20, C_STO = 8'h10,
                         C_FLG = 8'h08, C_ACK = 8'h04;
  localparam logic [6:0] SADDR = 7'h2A;

  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  bit mack_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model
  int bitn = 0, rdk = 0;
  bit active = 0, addrph = 0, s_tx = 0, nak_data = 0;
  logic [7:0] sh = 0, txb = 0;

  function automatic logic [7:0] rdbyte(input int k);
    return 8'hB1 + 8'(k * 38);
  endfunction

  always @(negedge sda) if (scl) begin
    bitn = 0; addrph = 1; active = 1; s_tx = 0; s_drive = 0;
  end
  always @(posedge sda) if (scl) begin active = 0; s_drive = 0; end

  always @(posedge scl) if (active) begin
    if (bitn < 8) sh = {sh[6:0], sda};
    else if (s_tx && !addrph) mack_q.push_back(!sda);
    bitn++;
  end

  always @(negedge scl) if (active) begin
    if (bitn == 8) begin
      if (addrph) begin
        if (sh[7:1] == SADDR) begin s_tx = sh[0]; s_drive = 1; end
        else begin active = 0; s_drive = 0; end
      end else if (!s_tx) begin
        // scoreboard monitor: bytes seen on the bus versus queued expectations (R4)
        if (exp_q.size() == 0) chk(0, "R4 unexpected byte", sh, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(sh == e, "R4 byte received by slave", sh, e);
        end
        s_drive = !nak_data;
      end else s_drive = 0;
    end else if (bitn == 9) begin
      bitn = 0;
      if (s_tx && (addrph || (mack_q.size() > 0 && mack_q[$]))) begin
        txb = rdbyte(rdk); rdk++; s_drive = !txb[7];
      end else begin
        s_drive = 0;
        if (s_tx) active = 0;
      end
      addrph = 0;
    end else if (s_tx && !addrph && bitn < 8) s_drive = !txb[7 - bitn];
  end

  int hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    if (scl) hi_cnt++;
    else begin if (hi_cnt != 0) last_hi = hi_cnt; hi_cnt = 0; end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, req, 0, 1);
  endtask

  task automatic expect_stat(input logic [7:0] code, input string req);
    logic [7:0] s;
    rd(3'd2, s);
    chk(s == code, req, s, code);
  endtask

  task automatic step(input logic [7:0] ctrl, input logic [7:0] code, input string req);
    wr(3'd0, ctrl); wait_flag(req); expect_stat(code, req);
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] code, input string req);
    wr(3'd1, b); step(C_EN | C_IE, code, req);
  endtask

  task automatic stop_idle(input logic [7:0] extra, input string req);
    logic [7:0] s = 0;
    int n = 0;
    wr(3'd0, C_EN | C_STO | extra);
    while (s != 8'hF8 && n < 2000) begin rd(3'd2, s); n++; end
    repeat (4) @(negedge clk);
    chk(s == 8'hF8, req, s, 8'hF8);
    chk(!irq && !scl_oe && !sda_oe, {req, " lines/flag"}, {irq, scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_stat(8'hF8, "R1 status after reset");
    rd(3'd0, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1 irq and lines", {irq, scl_oe, sda_oe}, 0);

    // R8 START ignored while disabled
    wr(3'd0, C_IE | C_STA);
    repeat (300) @(negedge clk);
    expect_stat(8'hF8, "R8 status with START disabled");
    rd(3'd0, v); chk(v[3] == 0, "R8 no flag", v[3], 0);
    chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);

    // R11 soft reset restores registers
    wr(3'd3, 8'h55); wr(3'd4, 8'h66); wr(3'd2, 8'h04);
    rd(3'd3, v); chk(v == 8'h55, "R11 own address write", v, 8'h55);
    wr(3'd5, 8'h9D);
    rd(3'd3, v); chk(v == 8'h00, "R11 own address cleared", v, 0);
    rd(3'd4, v); chk(v == 8'h00, "R11 ext address cleared", v, 0);
    rd(3'd0, v); chk(v == 8'h00, "R11 control cleared", v, 0);

    // default divider after soft reset (R10, R11), START and address (R2, R3)
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START status");
    chk(irq, "R9 irq with IE and flag", irq, 1);
    chk(scl_oe, "R12 SCL held while flag set", scl_oe, 1);
    send(8'h54, 8'h18, "R3 address write ACK");
    chk(last_hi == 138, "R10 R11 default divider SCL high", last_hi, 138);
    stop_idle(8'h00, "R7 STOP returns idle");

    // fast divider
    wr(3'd2, 8'h04);
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START status fast");
    send(8'h54, 8'h18, "R3 address write ACK fast");
    chk(last_hi == 10, "R10 divider 4 SCL high", last_hi, 10);
    exp_q.push_back(8'h9C); send(8'h9C, 8'h28, "R4 data ACK");
    exp_q.push_back(8'hC3); send(8'hC3, 8'h28, "R4 data ACK second");
    stop_idle(8'h00, "R7 STOP after write");
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);

    // address write NAK
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START");
    send(8'h40, 8'h20, "R3 address write NAK");
    stop_idle(8'h00, "R7 STOP after NAK");

    // data NAK
    nak_data = 1;
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START");
    send(8'h54, 8'h18, "R3 address write ACK");
    exp_q.push_back(8'h11); send(8'h11, 8'h30, "R4 data NAK");
    stop_idle(8'h00, "R7 STOP after data NAK");
    nak_data = 0;

    // repeated START with queued byte, then reads (R13, R2, R3, R5, R6)
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START");
    send(8'h54, 8'h18, "R3 address write ACK");
    exp_q.push_back(8'h07); send(8'h07, 8'h28, "R4 data ACK");
    wr(3'd1, 8'h55);
    step(C_EN | C_IE | C_STA, 8'h10, "R13 R2 repeated START wins over byte");
    step(C_EN | C_IE, 8'h40, "R13 R3 queued byte sent as read address");
    step(C_EN | C_IE | C_ACK, 8'h50, "R5 R6 receive with ACK");
    rd(3'd1, v); chk(v == rdbyte(0), "R5 first byte", v, rdbyte(0));
    chk(mack_q.size() == 1 && mack_q[0] == 1, "R5 master ACK on bus", mack_q.size(), 1);
    step(C_EN | C_IE, 8'h58, "R5 receive with NAK");
    rd(3'd1, v); chk(v == rdbyte(1), "R5 second byte", v, rdbyte(1));
    chk(mack_q.size() == 2 && mack_q[1] == 0, "R5 master NAK on bus", mack_q.size(), 2);
    stop_idle(8'h00, "R7 STOP after read");

    // address read NAK, then STOP and START together (R13)
    step(C_EN | C_IE | C_STA, 8'h08, "R2 START");
    send(8'h43, 8'h48, "R3 address read NAK");
    stop_idle(C_STA, "R13 STOP wins over START");
    rd(3'd0, v); chk(v[3] == 0, "R13 no flag after STOP", v[3], 0);

    // R9 and R6: flag without IE, write with flag bit set
    wr(3'd0, C_EN | C_STA);
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk(v[3] == 1, "R9 flag set without IE", v[3], 1);
    chk(!irq, "R9 irq low without IE", irq, 0);
    wr(3'd0, C_EN | C_IE | C_FLG);
    #1 chk(irq, "R9 irq follows IE", irq, 1);
    repeat (200) @(negedge clk);
    expect_stat(8'h08, "R6 flag-bit write launches nothing");
    chk(scl_oe, "R12 SCL still held", scl_oe, 1);
    stop_idle(8'h00, "R7 final STOP");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule